// File: doc/BRIEF.md
# Enumeration Vendor-Field Frame Builder

This block produces the 64-byte vendor-specific area of a periodic BOOTP request. The area goes out as an AXI4-Stream byte stream, one byte per beat, with TLAST on the final byte. A free-running timer raises a tick once per `TICK_CYCLES` clocks, which is about one second at the system clock rate. Each tick asks for one frame. The surrounding packet logic wraps the stream in the Ethernet, IP, UDP and BOOTP fixed fields and sends it to the broadcast address.

The frame contents come from three places. Board identity values are fixed at elaboration through parameters: a 128-bit board identifier, a 56-bit serial number, a 16-bit image CRC, a 32-bit miscellaneous word, a 16-bit IP version and a 32-bit ASCII signature. The port index and the PTP state are inputs, sampled once at frame start. A 16-bit sequence number is kept inside the block. Multi-byte fields use big-endian or little-endian order depending on the field.

Top module: `enum_field_streamer`

## Requirements
- R1: Byte 0 is 0xE0, byte 1 is 0x2B and byte 7 is 0x02. Bytes 2..5 hold `SIGNATURE` with the most significant byte first. Bytes 8, 9, 26..29 and 58..63 are 0x00.
- R2: Byte 6 is `{7'b0, port_sel_i}`, using the value sampled in the cycle the frame starts.
- R3: Bytes 10..25 hold `BOARD_ID` in big-endian order, so byte 10 = `BOARD_ID[127:120]`.
- R4: Four fields are little-endian. Bytes 30..36 hold `SERIAL_NUM` (byte 30 = bits 7:0). Bytes 37..38 hold `IP_VERSION`, bytes 39..40 hold `IMAGE_CRC` and bytes 41..44 hold `MISC_WORD`.
- R5: Bytes 45..54 hold `ptp_time_i` (48-bit seconds in bits 79:32, 32-bit nanoseconds in bits 31:0) in big-endian order, so byte 45 = bits 79:72. All ten bytes come from the value sampled in the frame-start cycle.
- R6: Bytes 55..56 hold the sequence number, high byte first. The first frame after reset carries 0. The number increments by one, modulo 2^16, after every accepted beat that has TLAST high.
- R7: Byte 57 is 0x01 when `ptp_enabled_i` and `ptp_synced_i` were both high in the frame-start cycle, and 0x00 otherwise.
- R8: Each frame is exactly 64 accepted beats. TLAST is high only on byte 63, and only while TVALID is high.
- R9: The timer ticks in the cycle its count, which starts at 0 after reset, reaches `TICK_CYCLES-1`, and then restarts from 0. With no frame in progress, TVALID rises two clocks after the tick.
- R10: While TVALID is high and TREADY is low, TVALID, TDATA and TLAST stay unchanged.
- R11: A tick during a frame, or while TREADY is low, is kept as one pending request. Further ticks before that request starts add nothing. The pending frame starts in the cycle after the current frame's last beat is accepted.
- R12: During reset and directly after it, TVALID is low and no frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel_i | input | 1 | Ethernet port index reported in byte 6 |
| ptp_time_i | input | 80 | Live PTP time: seconds [79:32], nanoseconds [31:0] |
| ptp_enabled_i | input | 1 | PTP function enabled |
| ptp_synced_i | input | 1 | A PTP sync message has been received |
| field_tvalid_o | output | 1 | Stream valid |
| field_tready_i | input | 1 | Stream ready from downstream |
| field_tdata_o | output | 8 | Stream byte |
| field_tlast_o | output | 1 | Last byte of the 64-byte field |

## Verification
Two events can land on the same clock edge. A timer tick can coincide with the start of a queued frame, which clears the pending request. A tick can also coincide with the accepted last beat of a frame, which advances the sequence number. The tick period is set shorter than the time a stalled frame takes, and TREADY is driven with random and long-held low patterns, so both coincidences occur many times. A reference model built on a byte queue, with its own tick counter and pending bit, predicts TVALID, TDATA and TLAST for every cycle. A lost or doubled request then shows up as a frame that starts too early or too late, or as a wrong sequence byte.

// File: rtl/enum_field_pkg.sv
package enum_field_pkg;

    localparam int unsigned FIELD_BYTES = 64;
    localparam int unsigned IDX_W       = $clog2(FIELD_BYTES);

    // byte positions inside the vendor area (decoded by the receiver)
    localparam int unsigned POS_TAG    = 0;
    localparam int unsigned POS_LEN    = 1;
    localparam int unsigned POS_SIG    = 2;
    localparam int unsigned LEN_SIG    = 4;
    localparam int unsigned POS_PORT   = 6;
    localparam int unsigned POS_VER    = 7;
    localparam int unsigned POS_ID     = 10;
    localparam int unsigned LEN_ID     = 16;
    localparam int unsigned POS_SN     = 30;
    localparam int unsigned LEN_SN     = 7;
    localparam int unsigned POS_IPV    = 37;
    localparam int unsigned LEN_IPV    = 2;
    localparam int unsigned POS_CRC    = 39;
    localparam int unsigned LEN_CRC    = 2;
    localparam int unsigned POS_MISC   = 41;
    localparam int unsigned LEN_MISC   = 4;
    localparam int unsigned POS_TIME   = 45;
    localparam int unsigned LEN_TIME   = 10;
    localparam int unsigned POS_SEQ    = 55;
    localparam int unsigned LEN_SEQ    = 2;
    localparam int unsigned POS_STATUS = 57;

    localparam logic [7:0] TAG_VALUE = 8'hE0;
    localparam logic [7:0] LEN_VALUE = 8'h2B;
    localparam logic [7:0] VER_VALUE = 8'h02;

    typedef struct packed {
        logic [8*LEN_TIME-1:0] ts;
        logic                  locked;
        logic                  port;
    } frame_snap_t;

endpackage

// File: rtl/enum_tick_gen.sv
module enum_tick_gen #(
    parameter int unsigned TICK_CYCLES = 156_250_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_COUNT = CW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] count;
    } tick_state_t;

    tick_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.count == LAST_COUNT) begin
            state_d.count = '0;
        end else begin
            state_d.count = state_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tick_o = (state_q.count == LAST_COUNT);

    initial begin
        assert (TICK_CYCLES >= 2) else $error("TICK_CYCLES must be at least 2");
    end

    // ticks are isolated pulses (R9)
    assert_tick_isolated_R9: assert property (
        @(posedge clk) disable iff (!rst_n) tick_o |=> !tick_o);

endmodule

// File: rtl/enum_frame_ctrl.sv
module enum_frame_ctrl
    import enum_field_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  port_sel_i,
    input  logic [8*LEN_TIME-1:0] ptp_time_i,
    input  logic                  ptp_enabled_i,
    input  logic                  ptp_synced_i,
    input  logic                  tready_i,
    output logic                  tvalid_o,
    output logic                  tlast_o,
    output logic [IDX_W-1:0]      beat_idx_o,
    output logic [15:0]           seq_o,
    output frame_snap_t           snap_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIELD_BYTES - 1);

    typedef struct packed {
        logic              active;
        logic              pending;
        logic [IDX_W-1:0]  idx;
        logic [15:0]       seq;
        frame_snap_t       snap;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;
    logic        beat_fire;
    logic        at_last;

    always_comb begin
        state_d   = state_q;
        beat_fire = state_q.active && tready_i;
        at_last   = (state_q.idx == LAST_IDX);

        if (beat_fire) begin
            if (at_last) begin
                state_d.active = 1'b0;
                state_d.idx    = '0;
                state_d.seq    = state_q.seq + 16'd1;
            end else begin
                state_d.idx    = state_q.idx + 1'b1;
            end
        end

        if (!state_q.active && state_q.pending) begin
            state_d.active      = 1'b1;
            state_d.pending     = 1'b0;
            state_d.idx         = '0;
            state_d.snap.ts     = ptp_time_i;
            state_d.snap.locked = ptp_enabled_i && ptp_synced_i;
            state_d.snap.port   = port_sel_i;
        end

        // a tick in the same cycle as a start re-arms the request
        if (tick_i) begin
            state_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tvalid_o   = state_q.active;
    assign tlast_o    = state_q.active && at_last;
    assign beat_idx_o = state_q.idx;
    assign seq_o      = state_q.seq;
    assign snap_o     = state_q.snap;

    assert_hold_on_stall_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tvalid_o && !tready_i) |=> (tvalid_o && $stable(beat_idx_o) && $stable(snap_o)));

    assert_last_needs_valid_R8: assert property (
        @(posedge clk) disable iff (!rst_n) tlast_o |-> tvalid_o);

    assert_seq_step_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tvalid_o && tready_i && tlast_o) |=> (seq_o == $past(seq_o) + 16'd1));

    assert_tick_queued_R11: assert property (
        @(posedge clk) disable iff (!rst_n) tick_i |=> state_q.pending);

    assert_snapshot_frozen_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        state_q.active |=> (!state_q.active || $stable(snap_o)));

    assert_seq_quiet_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(tvalid_o && tready_i && tlast_o) |=> $stable(seq_o));

endmodule

// File: rtl/enum_field_mux.sv
module enum_field_mux
    import enum_field_pkg::*;
#(
    parameter logic [31:0]  SIGNATURE  = 32'h454E554D,
    parameter logic [127:0] BOARD_ID   = '0,
    parameter logic [55:0]  SERIAL_NUM = '0,
    parameter logic [15:0]  IMAGE_CRC  = '0,
    parameter logic [31:0]  MISC_WORD  = '0,
    parameter logic [15:0]  IP_VERSION = '0
) (
    input  logic [IDX_W-1:0] beat_idx_i,
    input  frame_snap_t      snap_i,
    input  logic [15:0]      seq_i,
    output logic [7:0]       tdata_o
);
    logic [7:0] field_bytes [FIELD_BYTES];

    for (genvar b = 0; b < FIELD_BYTES; b++) begin : g_byte
        if (b == POS_TAG) begin : g_tag
            assign field_bytes[b] = TAG_VALUE;
        end else if (b == POS_LEN) begin : g_len
            assign field_bytes[b] = LEN_VALUE;
        end else if (b >= POS_SIG && b < POS_SIG + LEN_SIG) begin : g_sig
            assign field_bytes[b] = SIGNATURE[8*(LEN_SIG-1-(b-POS_SIG)) +: 8];
        end else if (b == POS_PORT) begin : g_port
            assign field_bytes[b] = {7'b0, snap_i.port};
        end else if (b == POS_VER) begin : g_ver
            assign field_bytes[b] = VER_VALUE;
        end else if (b >= POS_ID && b < POS_ID + LEN_ID) begin : g_id
            assign field_bytes[b] = BOARD_ID[8*(LEN_ID-1-(b-POS_ID)) +: 8];
        end else if (b >= POS_SN && b < POS_SN + LEN_SN) begin : g_sn
            assign field_bytes[b] = SERIAL_NUM[8*(b-POS_SN) +: 8];
        end else if (b >= POS_IPV && b < POS_IPV + LEN_IPV) begin : g_ipv
            assign field_bytes[b] = IP_VERSION[8*(b-POS_IPV) +: 8];
        end else if (b >= POS_CRC && b < POS_CRC + LEN_CRC) begin : g_crc
            assign field_bytes[b] = IMAGE_CRC[8*(b-POS_CRC) +: 8];
        end else if (b >= POS_MISC && b < POS_MISC + LEN_MISC) begin : g_misc
            assign field_bytes[b] = MISC_WORD[8*(b-POS_MISC) +: 8];
        end else if (b >= POS_TIME && b < POS_TIME + LEN_TIME) begin : g_time
            assign field_bytes[b] = snap_i.ts[8*(LEN_TIME-1-(b-POS_TIME)) +: 8];
        end else if (b >= POS_SEQ && b < POS_SEQ + LEN_SEQ) begin : g_seq
            assign field_bytes[b] = seq_i[8*(LEN_SEQ-1-(b-POS_SEQ)) +: 8];
        end else if (b == POS_STATUS) begin : g_status
            assign field_bytes[b] = {7'b0, snap_i.locked};
        end else begin : g_zero
            assign field_bytes[b] = 8'h00;
        end
    end

    assign tdata_o = field_bytes[beat_idx_i];

    // the header tag leads every frame (R1)
    always_comb begin
        if (beat_idx_i == IDX_W'(POS_TAG)) begin
            assert_tag_first_R1: assert (tdata_o == TAG_VALUE);
        end
    end

endmodule

// File: rtl/enum_field_streamer.sv
module enum_field_streamer
    import enum_field_pkg::*;
#(
    parameter int unsigned  TICK_CYCLES = 156_250_000,
    parameter logic [31:0]  SIGNATURE   = 32'h454E554D,
    parameter logic [127:0] BOARD_ID    = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    parameter logic [55:0]  SERIAL_NUM  = 56'h00_0000_0000_0001,
    parameter logic [15:0]  IMAGE_CRC   = 16'h0000,
    parameter logic [31:0]  MISC_WORD   = 32'h0000_0000,
    parameter logic [15:0]  IP_VERSION  = 16'h0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_sel_i,
    input  logic [79:0] ptp_time_i,
    input  logic        ptp_enabled_i,
    input  logic        ptp_synced_i,
    output logic        field_tvalid_o,
    input  logic        field_tready_i,
    output logic [7:0]  field_tdata_o,
    output logic        field_tlast_o
);
    logic             tick;
    logic [IDX_W-1:0] beat_idx;
    logic [15:0]      seq;
    frame_snap_t      snap;

    enum_tick_gen #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    enum_frame_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .port_sel_i    (port_sel_i),
        .ptp_time_i    (ptp_time_i),
        .ptp_enabled_i (ptp_enabled_i),
        .ptp_synced_i  (ptp_synced_i),
        .tready_i      (field_tready_i),
        .tvalid_o      (field_tvalid_o),
        .tlast_o       (field_tlast_o),
        .beat_idx_o    (beat_idx),
        .seq_o         (seq),
        .snap_o        (snap)
    );

    enum_field_mux #(
        .SIGNATURE  (SIGNATURE),
        .BOARD_ID   (BOARD_ID),
        .SERIAL_NUM (SERIAL_NUM),
        .IMAGE_CRC  (IMAGE_CRC),
        .MISC_WORD  (MISC_WORD),
        .IP_VERSION (IP_VERSION)
    ) u_mux (
        .beat_idx_i (beat_idx),
        .snap_i     (snap),
        .seq_i      (seq),
        .tdata_o    (field_tdata_o)
    );

    assert_data_stable_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (field_tvalid_o && !field_tready_i) |=> $stable(field_tdata_o));

endmodule

// File: tb/test_enum_field_streamer.sv
module test_enum_field_streamer;

    localparam int unsigned  TB_TICK = 90;
    localparam logic [31:0]  TB_SIG  = 32'h454E554D;
    localparam logic [127:0] TB_ID   = 128'hA1B2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F90;
    localparam logic [55:0]  TB_SN   = 56'h11_2233_4455_6677;
    localparam logic [15:0]  TB_CRC  = 16'hBEEF;
    localparam logic [31:0]  TB_MISC = 32'hC0DE_F00D;
    localparam logic [15:0]  TB_IPV  = 16'h0725;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_sel = 1'b0;
    logic [79:0] ptp_time = '0;
    logic        ptp_en = 1'b0;
    logic        ptp_sync = 1'b0;
    logic        tvalid;
    logic        tready = 1'b0;
    logic [7:0]  tdata;
    logic        tlast;

    int checks = 0;
    int fails  = 0;
    int frames_done = 0;

    always #4 clk = ~clk;

    enum_field_streamer #(
        .TICK_CYCLES (TB_TICK),
        .SIGNATURE   (TB_SIG),
        .BOARD_ID    (TB_ID),
        .SERIAL_NUM  (TB_SN),
        .IMAGE_CRC   (TB_CRC),
        .MISC_WORD   (TB_MISC),
        .IP_VERSION  (TB_IPV)
    ) i_enum_field_streamer (
        .clk            (clk),
        .rst_n          (rst_n),
        .port_sel_i     (port_sel),
        .ptp_time_i     (ptp_time),
        .ptp_enabled_i  (ptp_en),
        .ptp_synced_i   (ptp_sync),
        .field_tvalid_o (tvalid),
        .field_tready_i (tready),
        .field_tdata_o  (tdata),
        .field_tlast_o  (tlast)
    );

    // ---------------- reference model ----------------
    int         m_count;
    bit         m_pend;
    bit         m_act;
    bit [15:0]  m_seq;
    bit [7:0]   m_q[$];
    int         m_pos;

    function automatic string req_of(int pos);
        if (pos == 6) return "R2";
        if (pos >= 10 && pos <= 25) return "R3";
        if (pos >= 30 && pos <= 44) return "R4";
        if (pos >= 45 && pos <= 54) return "R5";
        if (pos == 55 || pos == 56) return "R6";
        if (pos == 57) return "R7";
        return "R1";
    endfunction

    task automatic build_frame();
        m_q = {};
        m_q.push_back(8'hE0);
        m_q.push_back(8'h2B);
        for (int k = 3; k >= 0; k--) m_q.push_back(TB_SIG[8*k +: 8]);
        m_q.push_back({7'b0, port_sel});
        m_q.push_back(8'h02);
        m_q.push_back(8'h00);
        m_q.push_back(8'h00);
        for (int k = 15; k >= 0; k--) m_q.push_back(TB_ID[8*k +: 8]);
        for (int k = 0; k < 4; k++) m_q.push_back(8'h00);
        for (int k = 0; k < 7; k++) m_q.push_back(TB_SN[8*k +: 8]);
        for (int k = 0; k < 2; k++) m_q.push_back(TB_IPV[8*k +: 8]);
        for (int k = 0; k < 2; k++) m_q.push_back(TB_CRC[8*k +: 8]);
        for (int k = 0; k < 4; k++) m_q.push_back(TB_MISC[8*k +: 8]);
        for (int k = 9; k >= 0; k--) m_q.push_back(ptp_time[8*k +: 8]);
        m_q.push_back(m_seq[15:8]);
        m_q.push_back(m_seq[7:0]);
        m_q.push_back({7'b0, ptp_en & ptp_sync});
        for (int k = 0; k < 6; k++) m_q.push_back(8'h00);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_pend = 0; m_act = 0; m_seq = 0; m_q = {}; m_pos = 0;
        end else begin
            bit tick_now;
            bit was_act;
            bit was_pend;
            tick_now = (m_count == TB_TICK - 1);
            m_count  = tick_now ? 0 : m_count + 1;
            was_act  = m_act;
            was_pend = m_pend;
            if (was_act && tready) begin
                void'(m_q.pop_front());
                m_pos++;
                if (m_q.size() == 0) begin
                    m_act = 0;
                    m_seq = m_seq + 16'd1;
                    frames_done++;
                end
            end
            if (!was_act && was_pend) begin
                build_frame();
                m_act = 1; m_pend = 0; m_pos = 0;
            end
            if (tick_now) m_pend = 1;
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_cycle();
        // R9 R11: frame timing follows tick and queuing rules
        check_bit("R9 R11", "tvalid", tvalid, m_act);
        if (m_act) begin
            // R8: TLAST only on the 64th byte
            check_bit("R8", "tlast", tlast, (m_q.size() == 1));
            checks++;
            if (tdata !== m_q[0]) begin
                fails++;
                $display("FAIL %s byte%0d actual=%02h expected=%02h t=%0t",
                         req_of(m_pos), m_pos, tdata, m_q[0], $time);
            end
        end
    endtask

    task automatic drive_random(int ready_pct);
        tready   = ($urandom_range(99) < ready_pct);
        ptp_time = {16'($urandom), $urandom, $urandom};
        port_sel = 1'($urandom);
        ptp_en   = 1'($urandom);
        ptp_sync = 1'($urandom);
    endtask

    task automatic run_phase(int cycles, int ready_pct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare_cycle();
            drive_random(ready_pct);
        end
    endtask

    bit done = 0;

    initial begin
        // R12: reset state
        repeat (4) @(negedge clk);
        check_bit("R12", "tvalid in reset", tvalid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R12", "tvalid after reset", tvalid, 1'b0);
        // R1 R2 R3 R4 R5 R6 R7 R8 R9: always ready, idle gaps between frames
        run_phase(600, 100);
        // R10 R11: random back-pressure, ticks land inside frames
        run_phase(2500, 55);
        // R11: long stall spanning several ticks, then release
        run_phase(400, 0);
        run_phase(400, 100);
        // R10: heavy back-pressure
        run_phase(1500, 25);
        run_phase(600, 90);
        // R6: sequence advanced once per completed frame
        checks++;
        if (frames_done < 10) begin
            fails++;
            $display("FAIL R6 frames completed actual=%0d expected>=10", frames_done);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule